// File: doc/BRIEF.md
# Coprocessor Pipeline Follower with Accept/Busy Handshake

This block is a slave coprocessor that sits beside a host processor on its shared instruction bus. Every word the host fetches is copied into a two-stage shadow pipeline (decode, then execute), so the unit always knows which instruction the host is about to execute. The host does its own instruction-class and condition evaluation. When it wants a coprocessor instruction executed, it pulls an active-low strobe. The unit then answers on two lines. One says whether it owns the instruction (absent when high). The other says whether it needs more time (busy when high).

Ownership is keyed on a 4-bit coprocessor number inside the instruction word. The unit claims only its own number, which is fixed by a parameter limited to the user range 4 to 7. For every other number it stays absent, so the host can raise its undefined-instruction trap when nobody answers. An owned instruction is held busy for a parameterized number of cycles. It then executes once: two operands are read from a private bank of sixteen 32-bit registers and the result is written back to that bank. A flush input empties the shadow pipeline after a branch or exception. A simple register port lets the system load and inspect the bank.

Top module: `copro_follower`

## Requirements
- R1: After reset, cpAbsent is 1, cpBusy is 0 and every bank register reads 0.
- R2: Each fetch with fetchValid high moves decode into execute and latches fetchWord into decode. A word therefore reaches execute on the fetch after its own, and while it sits in decode cpAbsent stays 1.
- R3: cpAbsent is 0 only while execute holds a word whose bits [27:24] equal 4'b1110 and whose bits [11:8] equal the CP_ID parameter. Every other of the 16 numbers leaves cpAbsent at 1 and cpBusy at 0. CP_ID must lie in 4 to 7.
- R4: A word whose bits [11:8] equal CP_ID but whose bits [27:24] differ from 4'b1110 is not claimed (cpAbsent stays 1).
- R5: For an owned word with cpiN low, cpBusy is 1 for exactly BUSY_CYCLES clock cycles of low strobe and then falls to 0.
- R6: On the first clock edge with cpiN low after busy ends, the owned word executes once. It writes register bits [15:12] with f(Rn = bank[bits 19:16], Rm = bank[bits 3:0]), where bits [23:20] select 0 Rn+Rm, 1 Rn-Rm, 2 Rn&Rm, 3 Rn|Rm, 4 Rn^Rm, 5 Rm. Codes 6 to 15 write nothing.
- R7: An owned word that leaves execute without cpiN ever going low changes no register.
- R8: A flush empties both stages: cpAbsent is 1 on the following cycle, and an owned word that was in flight, even mid-busy, never writes the bank.
- R9: While cpBusy is 1, fetches are ignored and the shadow pipeline holds its contents.
- R10: A port write with regWrEn high updates bank[regAddr] at the next edge. regRdData shows bank[regAddr] combinationally. If an executing instruction writes in the same cycle, the instruction's write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchValid | input | 1 | Host fetched an instruction this cycle |
| fetchWord | input | 32 | Instruction word on the shared bus |
| flush | input | 1 | Discard both follower stages |
| cpiN | input | 1 | Active-low request to execute the instruction in execute |
| cpAbsent | output | 1 | 1 when the unit does not own the execute-stage word |
| cpBusy | output | 1 | 1 while an owned, requested word is still waiting |
| regAddr | input | 4 | Bank register index for the access port |
| regWrEn | input | 1 | Port write enable |
| regWrData | input | 32 | Port write data |
| regRdData | output | 32 | Bank register at regAddr |

## Verification
The assertions check, on every cycle, the following properties. Busy never appears without ownership. The wait counter stays within its limit. Execute-stage content holds while busy. A flush leaves the unit absent on the next cycle. A register write lands one cycle after it is issued. Each execution strobe is a single-cycle pulse. Only the bench's directed scenarios can show the rest: the correct claim or silence for each of the 16 numbers, the exact busy length, the arithmetic results written to the bank, and that unrequested or flushed instructions leave registers untouched. The same holds for the ignored fetch during busy and the write-priority clash.

// File: rtl/copro_pkg.sv
package copro_pkg;
  localparam int WORD_W  = 32;
  localparam int IDX_W   = 4;
  localparam logic [3:0] CLASS_CODE = 4'b1110;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_MOV = 4'd5
  } copOp_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic             exec;
    logic [3:0]       op;
    logic [IDX_W-1:0] rd;
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rm;
  } copStrobe_t;

  function automatic logic [3:0] fieldClass(input logic [WORD_W-1:0] w);
    return w[27:24];
  endfunction

  function automatic logic [3:0] fieldCpNum(input logic [WORD_W-1:0] w);
    return w[11:8];
  endfunction
endpackage

// File: rtl/copro_follower_ctrl.sv
module copro_follower_ctrl
  import copro_pkg::*;
#(
  parameter int CP_ID       = 5,
  parameter int BUSY_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [WORD_W-1:0] fetchWord,
  input  logic              flush,
  input  logic              cpiN,
  output logic              cpAbsent,
  output logic              cpBusy,
  output copStrobe_t        strobe
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 2);
  localparam logic [CNT_W-1:0] BUSY_LIM = CNT_W'(BUSY_CYCLES);
  localparam logic [3:0] OWN_ID = 4'(CP_ID);

  logic [WORD_W-1:0] decWord, exeWord;
  logic              decValid, exeValid;
  logic [CNT_W-1:0]  waitCnt;
  logic              doneFlag;
  logic              ownHit, advance, execGo;
  logic              unusedBits;

  initial begin
    assert (CP_ID >= 4 && CP_ID <= 7) else $error("CP_ID outside user range 4..7");
  end

  assign ownHit  = exeValid && (fieldClass(exeWord) == CLASS_CODE)
                   && (fieldCpNum(exeWord) == OWN_ID);
  assign cpAbsent = !ownHit;
  assign cpBusy   = ownHit && !cpiN && !doneFlag && (waitCnt != BUSY_LIM);
  assign advance  = fetchValid && !cpBusy;
  assign execGo   = ownHit && !cpiN && !doneFlag && (waitCnt == BUSY_LIM) && !flush;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decWord  <= '0;
      exeWord  <= '0;
      decValid <= 1'b0;
      exeValid <= 1'b0;
      waitCnt  <= '0;
      doneFlag <= 1'b0;
    end else if (flush) begin
      decValid <= 1'b0;
      exeValid <= 1'b0;
      waitCnt  <= '0;
      doneFlag <= 1'b0;
    end else if (advance) begin
      decWord  <= fetchWord;
      decValid <= 1'b1;
      exeWord  <= decWord;
      exeValid <= decValid;
      waitCnt  <= '0;
      doneFlag <= 1'b0;
    end else begin
      if (cpBusy) waitCnt <= waitCnt + 1'b1;
      if (execGo) doneFlag <= 1'b1;
    end
  end

  always_comb begin
    strobe.exec = execGo;
    strobe.op   = exeWord[23:20];
    strobe.rn   = exeWord[19:16];
    strobe.rd   = exeWord[15:12];
    strobe.rm   = exeWord[3:0];
  end

  assign unusedBits = ^{exeWord[31:28], exeWord[7:4]};

  p_busy_owned_r5: assert property (@(posedge clk) disable iff (!rstN)
    cpBusy |-> !cpAbsent);
  p_wait_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= BUSY_LIM);
  p_hold_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cpBusy && !flush) |=> $stable(exeWord) && exeValid);
  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> cpAbsent);
  p_exec_once_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.exec |=> !strobe.exec);
endmodule

// File: rtl/copro_follower_dp.sv
module copro_follower_dp
  import copro_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  copStrobe_t        strobe,
  input  logic [IDX_W-1:0]  regAddr,
  input  logic              regWrEn,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData
);
  logic [WORD_W-1:0] bank [NUM_REGS];
  logic [WORD_W-1:0] opA, opB, result;
  logic              resValid;

  assign opA = bank[strobe.rn];
  assign opB = bank[strobe.rm];

  always_comb begin
    resValid = 1'b1;
    case (strobe.op)
      OP_ADD:  result = opA + opB;
      OP_SUB:  result = opA - opB;
      OP_AND:  result = opA & opB;
      OP_OR:   result = opA | opB;
      OP_XOR:  result = opA ^ opB;
      OP_MOV:  result = opB;
      default: begin
        result   = '0;
        resValid = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
    end else if (strobe.exec && resValid) begin
      bank[strobe.rd] <= result;
    end else if (regWrEn) begin
      bank[regAddr] <= regWrData;
    end
  end

  assign regRdData = bank[regAddr];

  p_port_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !strobe.exec) |=> bank[$past(regAddr)] == $past(regWrData));
endmodule

// File: rtl/copro_follower.sv
module copro_follower
  import copro_pkg::*;
#(
  parameter int CP_ID       = 5,
  parameter int BUSY_CYCLES = 3,
  parameter int NUM_REGS    = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fetchValid,
  input  logic [31:0] fetchWord,
  input  logic        flush,
  input  logic        cpiN,
  output logic        cpAbsent,
  output logic        cpBusy,
  input  logic [3:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData
);
  copStrobe_t strobe;

  copro_follower_ctrl #(.CP_ID(CP_ID), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchWord(fetchWord),
    .flush(flush), .cpiN(cpiN), .cpAbsent(cpAbsent), .cpBusy(cpBusy),
    .strobe(strobe)
  );

  copro_follower_dp #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData)
  );
endmodule

// File: tb/copro_follower_bench.sv
`timescale 1ns/1ps
module copro_follower_bench;
  localparam int OWN = 5;
  localparam int BUSY = 3;

  logic clk = 0, rstN = 0;
  logic fetchValid = 0, flush = 0, cpiN = 1, regWrEn = 0;
  logic [31:0] fetchWord = '0, regWrData = '0;
  logic [3:0] regAddr = '0;
  logic cpAbsent, cpBusy;
  logic [31:0] regRdData;
  int total = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  copro_follower #(.CP_ID(OWN), .BUSY_CYCLES(BUSY), .NUM_REGS(16)) u_copro_follower (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchWord(fetchWord),
    .flush(flush), .cpiN(cpiN), .cpAbsent(cpAbsent), .cpBusy(cpBusy),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData)
  );

  function automatic logic [31:0] mk(input logic [3:0] op, id, rd, rn, rm,
                                     input logic [3:0] cls = 4'b1110);
    return {4'hE, cls, op, rn, rd, id, 4'h0, rm};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [31:0] w);
    fetchValid = 1; fetchWord = w;
    @(negedge clk);
    fetchValid = 0;
  endtask

  task automatic loadInsn(input logic [31:0] w);
    pulse(w); pulse(32'h0);
  endtask

  task automatic doFlush();
    flush = 1; @(negedge clk); flush = 0;
  endtask

  task automatic portWrite(input logic [3:0] a, input logic [31:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic runOp(input logic [31:0] w, output int busyN,
                       input bit clash = 0, input logic [31:0] clashData = '0);
    loadInsn(w);
    cpiN = 0; #1;
    busyN = 0;
    while (cpBusy && busyN < 50) begin
      busyN++;
      @(negedge clk); #1;
    end
    if (clash) begin
      regWrEn = 1; regAddr = w[15:12]; regWrData = clashData;
    end
    @(negedge clk);
    cpiN = 1; regWrEn = 0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    bit allZero = 1;
    check(cpAbsent == 1, "R1 absent", 32'(cpAbsent), 1);
    check(cpBusy == 0, "R1 busy", 32'(cpBusy), 0);
    for (int i = 0; i < 16; i++) begin
      readReg(4'(i), d);
      if (d != 0) allZero = 0;
    end
    check(allZero, "R1 bank zero", 32'(allZero), 1);
  endtask

  task automatic testStages();
    pulse(mk(0, 4'(OWN), 1, 1, 1)); #1;
    check(cpAbsent == 1, "R2 word in decode not claimed", 32'(cpAbsent), 1);
    pulse(32'h0); #1;
    check(cpAbsent == 0, "R2 word reaches execute", 32'(cpAbsent), 0);
    doFlush();
  endtask

  task automatic testIdSweep();
    for (int id = 0; id < 16; id++) begin
      loadInsn(mk(0, 4'(id), 1, 1, 1));
      cpiN = 0; #1;
      check(cpAbsent == (id != OWN), $sformatf("R3 id %0d absent", id),
            32'(cpAbsent), 32'(id != OWN));
      if (id != OWN) check(cpBusy == 0, $sformatf("R3 id %0d busy", id), 32'(cpBusy), 0);
      cpiN = 1;
      doFlush();
    end
  endtask

  task automatic testClass();
    loadInsn(mk(0, 4'(OWN), 1, 1, 1, 4'b1100)); #1;
    check(cpAbsent == 1, "R4 wrong class", 32'(cpAbsent), 1);
    doFlush();
  endtask

  task automatic testOps();
    int b;
    logic [31:0] d;
    portWrite(1, 32'd100);
    portWrite(2, 32'd30);
    portWrite(10, 32'hABCD);
    readReg(1, d);
    check(d == 100, "R10 port write", d, 100);
    runOp(mk(0, 4'(OWN), 3, 1, 2), b);
    check(b == BUSY, "R5 busy length", 32'(b), BUSY);
    readReg(3, d); check(d == 130, "R6 add", d, 130);
    runOp(mk(1, 4'(OWN), 4, 1, 2), b);
    readReg(4, d); check(d == 70, "R6 sub", d, 70);
    runOp(mk(1, 4'(OWN), 5, 2, 1), b);
    readReg(5, d); check(d == 32'hFFFFFFBA, "R6 sub negative", d, 32'hFFFFFFBA);
    runOp(mk(2, 4'(OWN), 6, 1, 2), b);
    readReg(6, d); check(d == 4, "R6 and", d, 4);
    runOp(mk(3, 4'(OWN), 7, 1, 2), b);
    readReg(7, d); check(d == 126, "R6 or", d, 126);
    runOp(mk(4, 4'(OWN), 8, 1, 2), b);
    readReg(8, d); check(d == 122, "R6 xor", d, 122);
    runOp(mk(5, 4'(OWN), 9, 1, 2), b);
    readReg(9, d); check(d == 30, "R6 move", d, 30);
    runOp(mk(7, 4'(OWN), 10, 1, 2), b);
    readReg(10, d); check(d == 32'hABCD, "R6 undefined op no write", d, 32'hABCD);
    #1; check(cpBusy == 0, "R5 busy low after exec", 32'(cpBusy), 0);
  endtask

  task automatic testNoStrobe();
    logic [31:0] d;
    portWrite(11, 32'h55);
    loadInsn(mk(0, 4'(OWN), 11, 1, 2));
    pulse(32'h0); pulse(32'h0); #1;
    readReg(11, d);
    check(d == 32'h55, "R7 unrequested no write", d, 32'h55);
    check(cpAbsent == 1, "R7 word left execute", 32'(cpAbsent), 1);
  endtask

  task automatic testFlush();
    logic [31:0] d;
    portWrite(12, 32'h77);
    loadInsn(mk(0, 4'(OWN), 12, 1, 2));
    cpiN = 0; @(negedge clk);
    flush = 1; @(negedge clk);
    flush = 0; #1;
    check(cpAbsent == 1, "R8 absent after flush", 32'(cpAbsent), 1);
    repeat (BUSY + 2) @(negedge clk);
    cpiN = 1;
    readReg(12, d);
    check(d == 32'h77, "R8 flushed no write", d, 32'h77);
  endtask

  task automatic testFetchDuringBusy();
    logic [31:0] d;
    loadInsn(mk(0, 4'(OWN), 13, 1, 2));
    cpiN = 0;
    @(negedge clk);
    pulse(mk(5, 4'(OWN), 14, 1, 2));
    while (cpBusy) @(negedge clk);
    @(negedge clk);
    cpiN = 1;
    readReg(13, d);
    check(d == 130, "R9 op still completes", d, 130);
    pulse(32'h0); #1;
    check(cpAbsent == 1, "R9 busy fetch was ignored", 32'(cpAbsent), 1);
    doFlush();
  endtask

  task automatic testClash();
    int b;
    logic [31:0] d;
    runOp(mk(0, 4'(OWN), 15, 1, 2), b, 1, 32'hDEAD);
    readReg(15, d);
    check(d == 130, "R10 instruction write wins", d, 130);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;
    testReset();
    testStages();
    testIdSweep();
    testClass();
    testOps();
    testNoStrobe();
    testFlush();
    testFetchDuringBusy();
    testClash();
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule